// File: doc/BRIEF.md
# Receive Error and Pending Packet Counter

This block sits beside a receive packet buffer. It counts the received packets that are waiting for firmware, and it decides when a packet that is arriving must be dropped. A packet is dropped when buffer space runs out during the packet, when the pending count is already at its ceiling, or when the receive path cannot get enough memory bandwidth. Firmware releases a packet by pulsing a decrement strobe.

Every drop produces a one-cycle abort pulse and sets a sticky receive-error flag. A drop caused by lack of bandwidth also sets a separate sticky buffer-error bit. A small write port lets firmware clear either flag and program two enables. The interrupt request is raised only while the error flag is set and both enables are on. The counter width is a parameter, and a second parameter chooses whether the interrupt output is combinational or registered.

Top module: `rxerr_pktcnt`

## Requirements
- R1: A packet is active from the cycle of `pkt_start` until its `pkt_done` or its abort. `pkt_done` in an active cycle with no abort adds one to `pend_cnt` after that clock edge. A packet may start and finish in the same cycle.
- R2: `buf_full` in any active cycle aborts the packet, and that packet is never counted.
- R3: An active cycle while `pend_cnt` equals 2**CNT_W-1 aborts the packet. `pend_cnt` never wraps past that value.
- R4: `bw_fail` in an active cycle aborts the packet and sets `buf_err` on the same edge as `rx_err`.
- R5: `pkt_abort` is high for exactly the one cycle after each abort cycle, and `rx_err` sets on that same edge.
- R6: `rx_err` stays set until a write with `reg_sel`=0 and `reg_wdata[0]`=1. If an abort and a clear fall in the same cycle, the flag ends set.
- R7: `buf_err` is cleared only by a write with `reg_sel`=0 and `reg_wdata[1]`=1. If a set and a clear fall in the same cycle, the set wins.
- R8: A write with `reg_sel`=1 loads the error enable from `reg_wdata[0]` and the global enable from `reg_wdata[1]`. When IRQ_REG=0, `irq` equals `rx_err` AND both enables.
- R9: `pkt_dec` lowers `pend_cnt` by one. A `pkt_dec` while `pend_cnt` is 0 has no effect.
- R10: An increment and a `pkt_dec` in the same cycle leave `pend_cnt` unchanged.
- R11: After reset, `pend_cnt` is 0, all flags and enables are 0, and no packet is active.
- R12: `pkt_done`, `buf_full` and `bw_fail` have no effect when no packet is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_start | input | 1 | Strobe: a packet begins |
| pkt_done | input | 1 | Strobe: the packet completes |
| buf_full | input | 1 | No buffer space left |
| bw_fail | input | 1 | Receive path lost memory bandwidth |
| pkt_dec | input | 1 | Firmware releases one pending packet |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: clear register, 1: enable register |
| reg_wdata | input | 2 | Write data |
| pend_cnt | output | CNT_W | Pending packet count |
| rx_err | output | 1 | Sticky receive-error flag |
| buf_err | output | 1 | Sticky buffer-error bit |
| pkt_abort | output | 1 | One-cycle packet-abort pulse |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with CNT_W=3, which puts the count ceiling at 7. Filling the counter, aborting at the ceiling and draining it back to zero therefore take only a few dozen cycles. IRQ_REG is left at 0, so `irq` can be compared against the gating rule in the same cycle as the flag and the enables. A behavioural model predicts every output on every clock. The stimulus also makes an abort and a clear collide, makes an increment and a decrement meet in one cycle, and uses starts and completions that fall in a single cycle.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
   typedef enum logic {
      REG_CLR = 1'b0,
      REG_EN  = 1'b1
   } rxe_reg_e;

   localparam int CLR_RXERR_BIT  = 0;
   localparam int CLR_BUFERR_BIT = 1;
   localparam int EN_RXERR_BIT   = 0;
   localparam int EN_GLOBAL_BIT  = 1;
   localparam int REG_DW         = 2;
endpackage

// File: rtl/rxe_abort_det.sv
module rxe_abort_det (
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_start,
   input  logic pkt_done,
   input  logic buf_full,
   input  logic bw_fail,
   input  logic cnt_full,
   output logic abort_now,
   output logic accept,
   output logic bw_hit,
   output logic pkt_abort
);
   logic active_q, active_d, live;

   assign live      = pkt_start | active_q;
   assign abort_now = live & (buf_full | bw_fail | cnt_full);
   assign accept    = live & pkt_done & ~abort_now;
   assign bw_hit    = live & bw_fail;

   always_comb begin
      if (abort_now)      active_d = 1'b0;
      else if (pkt_start) active_d = ~pkt_done;
      else                active_d = active_q & ~pkt_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         pkt_abort <= 1'b0;
      end else begin
         active_q  <= active_d;
         pkt_abort <= abort_now;
      end
   end
endmodule

// File: rtl/rxe_pend_cnt.sv
module rxe_pend_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_full
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             do_up, do_down;

   assign cnt_full = (cnt_q == CNT_MAX);
   assign do_up    = inc & ~dec & ~cnt_full;
   assign do_down  = dec & ~inc & (cnt_q != '0);
   assign cnt      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (do_up)   cnt_q <= cnt_q + CNT_ONE;
      else if (do_down) cnt_q <= cnt_q - CNT_ONE;
   end
endmodule

// File: rtl/rxe_flags.sv
module rxe_flags
   import rxe_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_now,
   input  logic              bw_hit,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic              rx_err,
   output logic              buf_err,
   output logic              irq
);
   logic clr_wr, en_wr, rx_err_q, buf_err_q, en_rx_q, en_glb_q, irq_raw;

   assign clr_wr = reg_we & (rxe_reg_e'(reg_sel) == REG_CLR);
   assign en_wr  = reg_we & (rxe_reg_e'(reg_sel) == REG_EN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_err_q  <= 1'b0;
         buf_err_q <= 1'b0;
         en_rx_q   <= 1'b0;
         en_glb_q  <= 1'b0;
      end else begin
         if (abort_now)                             rx_err_q <= 1'b1;
         else if (clr_wr && reg_wdata[CLR_RXERR_BIT]) rx_err_q <= 1'b0;
         if (bw_hit)                                 buf_err_q <= 1'b1;
         else if (clr_wr && reg_wdata[CLR_BUFERR_BIT]) buf_err_q <= 1'b0;
         if (en_wr) begin
            en_rx_q  <= reg_wdata[EN_RXERR_BIT];
            en_glb_q <= reg_wdata[EN_GLOBAL_BIT];
         end
      end
   end

   assign irq_raw = rx_err_q & en_rx_q & en_glb_q;
   assign rx_err  = rx_err_q;
   assign buf_err = buf_err_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/rxerr_pktcnt.sv
module rxerr_pktcnt
   import rxe_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_start,
   input  logic              pkt_done,
   input  logic              buf_full,
   input  logic              bw_fail,
   input  logic              pkt_dec,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [CNT_W-1:0]  pend_cnt,
   output logic              rx_err,
   output logic              buf_err,
   output logic              pkt_abort,
   output logic              irq
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("rxerr_pktcnt: CNT_W must lie in 2..16");
      end
   endgenerate

   logic abort_now, accept, bw_hit, cnt_full;

   rxe_abort_det u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_start (pkt_start),
      .pkt_done  (pkt_done),
      .buf_full  (buf_full),
      .bw_fail   (bw_fail),
      .cnt_full  (cnt_full),
      .abort_now (abort_now),
      .accept    (accept),
      .bw_hit    (bw_hit),
      .pkt_abort (pkt_abort)
   );

   rxe_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (accept),
      .dec      (pkt_dec),
      .cnt      (pend_cnt),
      .cnt_full (cnt_full)
   );

   rxe_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_now (abort_now),
      .bw_hit    (bw_hit),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .rx_err    (rx_err),
      .buf_err   (buf_err),
      .irq       (irq)
   );
endmodule

// File: rtl/rxerr_pktcnt_chk.sv
module rxerr_pktcnt_chk #(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_dec,
   input logic             reg_we,
   input logic             reg_sel,
   input logic [1:0]       reg_wdata,
   input logic [CNT_W-1:0] pend_cnt,
   input logic             rx_err,
   input logic             buf_err,
   input logic             pkt_abort,
   input logic             irq
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt != $past(pend_cnt) |->
         (pend_cnt == $past(pend_cnt) + ONE || pend_cnt == $past(pend_cnt) - ONE));

   assert_no_count_on_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_abort |-> pend_cnt != $past(pend_cnt) + ONE);

   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pend_cnt) == CMAX |-> pend_cnt != '0);

   assert_buf_err_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_err) |-> rx_err);

   assert_abort_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_abort |-> rx_err);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err && !(reg_we && !reg_sel && reg_wdata[0]) |=> rx_err);

   assert_buf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_err && !(reg_we && !reg_sel && reg_wdata[1]) |=> buf_err);

   generate
      if (IRQ_REG) begin : g_irq_reg
         assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(rx_err));
      end else begin : g_irq_comb
         assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> rx_err);
      end
   endgenerate

   assert_dec_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt == '0 && pkt_dec |=> pend_cnt <= ONE);
endmodule

bind rxerr_pktcnt rxerr_pktcnt_chk #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pkt_dec   (pkt_dec),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .pend_cnt  (pend_cnt),
   .rx_err    (rx_err),
   .buf_err   (buf_err),
   .pkt_abort (pkt_abort),
   .irq       (irq)
);

// File: tb/tb_rxerr_pktcnt.sv
`timescale 1ns/1ps
module tb_rxerr_pktcnt;
   localparam int CW   = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pkt_start = 0, pkt_done = 0, buf_full = 0, bw_fail = 0, pkt_dec = 0;
   logic reg_we = 0, reg_sel = 0;
   logic [1:0] reg_wdata = '0;
   logic [CW-1:0] pend_cnt;
   logic rx_err, buf_err, pkt_abort, irq;

   int tests = 0, fails = 0;

   // behavioural reference state
   int m_cnt = 0;
   bit m_act = 0, m_abort = 0, m_rx = 0, m_buf = 0, m_enr = 0, m_eng = 0;

   always #2 clk = ~clk;

   rxerr_pktcnt #(.CNT_W(CW), .IRQ_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_done(pkt_done),
      .buf_full(buf_full), .bw_fail(bw_fail), .pkt_dec(pkt_dec),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .pend_cnt(pend_cnt), .rx_err(rx_err), .buf_err(buf_err),
      .pkt_abort(pkt_abort), .irq(irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_act = 0; m_abort = 0; m_rx = 0; m_buf = 0; m_enr = 0; m_eng = 0;
      end else begin
         bit live, ab, up;
         live = pkt_start || m_act;
         ab   = live && (buf_full || bw_fail || m_cnt == CMAX);
         up   = live && pkt_done && !ab;
         if (up && pkt_dec) ;
         else if (up) m_cnt = m_cnt + 1;
         else if (pkt_dec && m_cnt > 0) m_cnt = m_cnt - 1;
         if (ab) m_act = 0;
         else if (pkt_start) m_act = !pkt_done;
         else if (pkt_done) m_act = 0;
         m_abort = ab;
         if (ab) m_rx = 1;
         else if (reg_we && !reg_sel && reg_wdata[0]) m_rx = 0;
         if (live && bw_fail) m_buf = 1;
         else if (reg_we && !reg_sel && reg_wdata[1]) m_buf = 0;
         if (reg_we && reg_sel) begin m_enr = reg_wdata[0]; m_eng = reg_wdata[1]; end
      end
   end

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 R3 R9 R10 pend_cnt", int'(pend_cnt), m_cnt);
      chk("R5 pkt_abort", int'(pkt_abort), int'(m_abort));
      chk("R6 rx_err", int'(rx_err), int'(m_rx));
      chk("R4 R7 buf_err", int'(buf_err), int'(m_buf));
      chk("R8 irq", int'(irq), int'(m_rx && m_enr && m_eng));
   endtask

   task automatic cyc(bit s, bit d, bit f, bit b, bit dc, bit we = 0, bit sel = 0, logic [1:0] wd = 2'b00);
      pkt_start = s; pkt_done = d; buf_full = f; bw_fail = b; pkt_dec = dc;
      reg_we = we; reg_sel = sel; reg_wdata = wd;
      @(negedge clk);
      compare_all();
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset values
      chk("R11 pend_cnt", int'(pend_cnt), 0);
      chk("R11 rx_err", int'(rx_err), 0);
      chk("R11 buf_err", int'(buf_err), 0);
      chk("R11 irq", int'(irq), 0);
      rst_n = 1'b1;
      cyc(0,0,0,0,0);
      // R1: multi-cycle packet, then single-cycle packet
      cyc(1,0,0,0,0); cyc(0,0,0,0,0); cyc(0,1,0,0,0);
      cyc(1,1,0,0,0); cyc(0,0,0,0,0);
      chk("R1 two packets counted", int'(pend_cnt), 2);
      // R12: stray done, full and bw_fail with no packet active
      cyc(0,1,0,0,0); cyc(0,0,1,1,0); cyc(0,0,0,0,0);
      chk("R12 idle strobes ignored", int'(pend_cnt) + int'(rx_err) + int'(buf_err), 2);
      // R2: buffer full mid-packet; later done does not count
      cyc(1,0,0,0,0); cyc(0,0,1,0,0); cyc(0,1,0,0,0); cyc(0,0,0,0,0);
      chk("R2 aborted packet not counted", int'(pend_cnt), 2);
      // R8: enables, one at a time then both
      cyc(0,0,0,0,0,1,1,2'b01); cyc(0,0,0,0,0,1,1,2'b10); cyc(0,0,0,0,0,1,1,2'b11);
      cyc(0,0,0,0,0,1,0,2'b01); // R6 clear rx_err
      // R4: bandwidth fail during packet
      cyc(1,0,0,0,0); cyc(0,0,0,1,0); cyc(0,0,0,0,0);
      chk("R4 buf_err set", int'(buf_err), 1);
      cyc(0,0,0,0,0,1,0,2'b01); // R7: clearing rx_err only leaves buf_err
      cyc(0,0,0,0,0,1,0,2'b10);
      // R6 R7: abort and clear in the same cycle, set wins
      cyc(1,0,0,1,0,1,0,2'b11); cyc(0,0,0,0,0);
      chk("R6 set wins over clear", int'(rx_err), 1);
      cyc(0,0,0,0,0,1,0,2'b11);
      // R10: completion and decrement together
      cyc(1,1,0,0,1); cyc(0,0,0,0,0);
      chk("R10 inc+dec unchanged", int'(pend_cnt), 2);
      // R3: fill to ceiling, further packet aborts
      for (int i = 0; i < CMAX; i++) cyc(1,1,0,0,0);
      chk("R3 count saturated", int'(pend_cnt), CMAX);
      cyc(1,0,0,0,0); cyc(0,1,0,0,0);
      chk("R3 packet at ceiling aborted", int'(rx_err), 1);
      // back-to-back aborts: pulse on each
      cyc(1,1,0,0,0); cyc(1,1,0,0,0);
      // R9: drain below zero
      for (int i = 0; i < CMAX + 3; i++) cyc(0,0,0,0,1);
      chk("R9 drained to zero", int'(pend_cnt), 0);
      cyc(1,1,0,0,1); cyc(0,0,0,0,0); // R10 at zero
      cyc(0,0,0,0,0,1,1,2'b00); cyc(0,0,0,0,0);
      finish_run();
   end
endmodule